// File: doc/BRIEF.md
# Latched GPIO Port Register

This block is an eight-pin general-purpose I/O port for a small microcontroller bus. It keeps a direction register and an output latch. It also offers a port view that shows the live, synchronised pin levels. A synchronous register bus reads and writes these views. The same bus also carries single-bit set, clear and toggle commands, each done as a one-cycle read-modify-write. Every pin connects to a tri-state pad through three signals: a drive value, a drive enable and a sampled input.

The port view and the latch view read from different sources. Port reads return pad levels and latch reads return the stored latch. Writes to either address store into the latch. A bit command's read stage uses the view at the addressed register, so the outcome depends on the address:

- At the latch address, the command leaves every other latch bit untouched.
- At the port address, the command copies the pad levels of the input pins into the latch.

The register bus uses a two-state response machine.

- **BUS_IDLE** moves to **BUS_RESP** when `bus_rd` is high. This transition is named *take_read*.
- **BUS_RESP** stays in **BUS_RESP** when another read follows at once. This transition is *chain_read*.
- **BUS_RESP** returns to **BUS_IDLE** otherwise. This transition is *release*.
- `bus_rvalid` is high only in **BUS_RESP**.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset, every direction bit is 1 (input) and the latch is 0x00. All `pad_oe` bits are 0 and `bus_rvalid` is 0.
- R2: A bus write to address 1 (port) or address 2 (latch) stores the write data in the latch and leaves the direction register unchanged. A write to address 0 stores the data in the direction register.
- R3: A read of address 2 returns the latch contents, whatever the pin levels are.
- R4: A read of address 1 returns the pad levels after a two-flop synchroniser, whatever the direction bits are. A pad change made just after a clock edge is not seen by a read issued one cycle later. It is seen by a read issued two cycles later.
- R5: Read data appears on `bus_rdata` with `bus_rvalid` high in the cycle after `bus_rd`. Back-to-back reads give back-to-back responses. Address 3 reads as 0x00, and writes to address 3 change nothing.
- R6: A pin whose direction bit is 0 has `pad_oe` set and drives its latch bit on `pad_out`. A pin whose direction bit is 1 has `pad_oe` clear and `pad_out` low.
- R7: A bit command is taken when `bit_op` is non-zero and `bus_wr` is low. The opcode values are 01 for set, 10 for clear and 11 for toggle; 00 does nothing. `bit_idx` selects the bit, and the result is stored at the next edge. When `bus_wr` is high in the same cycle, the bit command is ignored.
- R8: A bit command at address 2 reads the latch itself, so all other latch bits keep their values.
- R9: A bit command at address 1 reads the synchronised pad levels. It changes the selected bit and stores all bits into the latch, so each input pin's latch bit takes its current pad level.
- R10: A bit command at address 0 modifies the direction register from its own contents.
- R11: When a pin turns from input to output, it drives the latch value from the next cycle on. This includes a value left in the latch by an earlier port-address bit command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register select: 0 direction, 1 port, 2 latch, 3 unused |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response valid, one cycle after bus_rd |
| bit_op | input | 2 | Bit command: 00 none, 01 set, 10 clear, 11 toggle |
| bit_idx | input | 3 | Bit selected by the bit command |
| pad_in | input | 8 | Pad input levels (asynchronous) |
| pad_out | output | 8 | Pad drive values |
| pad_oe | output | 8 | Pad drive enables, 1 = driven |

## Verification
The bench builds the block with its default eight pins and a two-stage synchroniser. With these values a single byte pattern shows the effects that matter. Pins 4 to 7 are outputs and pins 0 to 3 are inputs, so a port read, a latch read and a port-address bit command all return different bytes. This shows the corruption of input-pin latch bits directly. The bench models the pads itself: a pin follows `pad_out` when enabled and an external level otherwise. This brings the read-back of driven pins through the two-cycle synchroniser, and the exact latency boundary, within reach.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int unsigned ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_DIR  = 2'd0,
        REG_PORT = 2'd1,
        REG_LAT  = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        BOP_NONE = 2'b00,
        BOP_SET  = 2'b01,
        BOP_CLR  = 2'b10,
        BOP_TGL  = 2'b11
    } bitop_e;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/gpio_bitop.sv
module gpio_bitop
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic [WIDTH-1:0] src,
    input  logic [1:0]       op,
    input  logic [IDX_W-1:0] idx,
    output logic [WIDTH-1:0] result
);
    logic [WIDTH-1:0] mask;

    always_comb begin
        mask = '0;
        mask[idx] = 1'b1;
        unique case (bitop_e'(op))
            BOP_SET:  result = src | mask;
            BOP_CLR:  result = src & ~mask;
            BOP_TGL:  result = src ^ mask;
            default:  result = src;
        endcase
    end
endmodule

// File: rtl/gpio_pad_drv.sv
module gpio_pad_drv #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] dir,
    input  logic [WIDTH-1:0] lat,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe
);
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_pin
            assign pad_oe[i]  = ~dir[i];
            assign pad_out[i] = ~dir[i] & lat[i];
        end
    endgenerate
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2,
    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [WIDTH-1:0]  bus_wdata,
    input  logic              bus_rd,
    output logic [WIDTH-1:0]  bus_rdata,
    output logic              bus_rvalid,
    input  logic [1:0]        bit_op,
    input  logic [IDX_W-1:0]  bit_idx,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_oe
);
    bus_state_e       state_q, state_d;
    logic [WIDTH-1:0] dir_q, lat_q, sync_q;
    logic [WIDTH-1:0] view, modified, rdata_q;
    logic             bit_take;

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (sync_q)
    );

    // View at the addressed register: the read side of reads and bit commands.
    always_comb begin
        unique case (reg_sel_e'(bus_addr))
            REG_DIR:  view = dir_q;
            REG_PORT: view = sync_q;
            REG_LAT:  view = lat_q;
            default:  view = '0;
        endcase
    end

    gpio_bitop #(.WIDTH(WIDTH)) i_bitop (
        .src    (view),
        .op     (bit_op),
        .idx    (bit_idx),
        .result (modified)
    );

    assign bit_take = !bus_wr && (bitop_e'(bit_op) != BOP_NONE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '1;
            lat_q <= '0;
        end else if (bus_wr) begin
            unique case (reg_sel_e'(bus_addr))
                REG_DIR:          dir_q <= bus_wdata;
                REG_PORT, REG_LAT: lat_q <= bus_wdata;
                default:          ;
            endcase
        end else if (bit_take) begin
            unique case (reg_sel_e'(bus_addr))
                REG_DIR:          dir_q <= modified;
                REG_PORT, REG_LAT: lat_q <= modified;
                default:          ;
            endcase
        end
    end

    gpio_pad_drv #(.WIDTH(WIDTH)) i_pad (
        .dir     (dir_q),
        .lat     (lat_q),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    // Response state machine: state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (bus_rd) rdata_q <= view;
        end
    end

    // Next-state logic: take_read, chain_read, release.
    always_comb begin
        unique case (state_q)
            BUS_IDLE: state_d = bus_rd ? BUS_RESP : BUS_IDLE;
            BUS_RESP: state_d = bus_rd ? BUS_RESP : BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    // Output process.
    always_comb begin
        unique case (state_q)
            BUS_RESP: begin
                bus_rvalid = 1'b1;
                bus_rdata  = rdata_q;
            end
            default: begin
                bus_rvalid = 1'b0;
                bus_rdata  = '0;
            end
        endcase
    end
endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [WIDTH-1:0]  bus_wdata,
    input logic              bus_rd,
    input logic [WIDTH-1:0]  bus_rdata,
    input logic              bus_rvalid,
    input logic [1:0]        bit_op,
    input logic [IDX_W-1:0]  bit_idx,
    input logic [WIDTH-1:0]  pad_out,
    input logic [WIDTH-1:0]  pad_oe,
    input logic [WIDTH-1:0]  lat_q,
    input logic [WIDTH-1:0]  dir_q,
    input logic [WIDTH-1:0]  sync_q
);
    a_r5_rvalid_follows_rd: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);

    a_r5_no_spurious_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid);

    a_r3_latch_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd2) |=> bus_rdata == $past(lat_q));

    a_r4_port_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd1) |=> bus_rdata == $past(sync_q));

    a_r2_port_write_to_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd1) |=> (lat_q == $past(bus_wdata)) && $stable(dir_q));

    a_r6_oe_after_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0) |=> pad_oe == ~$past(bus_wdata));

    a_r8_latch_bitop_preserves: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && bit_op != 2'b00 && bus_addr == 2'd2) |=>
        ((lat_q ^ $past(lat_q)) & ~(WIDTH'(1) << $past(bit_idx))) == '0);

    a_r7_none_op_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && bit_op == 2'b00) |=> $stable(lat_q) && $stable(dir_q));

    always_comb begin
        if (rst_n) begin
            a_r6_undriven_low: assert ((pad_out & ~pad_oe) == '0);
        end
    end
endmodule

bind gpio_port_regs gpio_port_regs_chk #(.WIDTH(WIDTH)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rd     (bus_rd),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .bit_op     (bit_op),
    .bit_idx    (bit_idx),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe),
    .lat_q      (lat_q),
    .dir_q      (dir_q),
    .sync_q     (sync_q)
);

// File: tb/test_gpio_port_regs.sv
module test_gpio_port_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic       bus_rvalid;
    logic [1:0] bit_op = '0;
    logic [2:0] bit_idx = '0;
    logic [7:0] pad_in, pad_out, pad_oe;
    logic [7:0] ext = '0;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    // Pad model: driven pins follow pad_out, others follow the external level.
    assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

    gpio_port_regs i_gpio_port_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .bit_op(bit_op), .bit_idx(bit_idx),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(logic [1:0] a, logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Driver: issue a read and push the expected response.
    task automatic bus_read(logic [1:0] a, logic [7:0] exp, string tag);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic bitcmd(logic [1:0] a, logic [1:0] op, logic [2:0] idx);
        bus_addr = a; bit_op = op; bit_idx = idx;
        @(negedge clk);
        bit_op = 2'b00;
    endtask

    // Monitor: pop and compare each response.
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R5 unexpected response actual=%h expected=none", bus_rdata);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R5 watchdog actual=timeout expected=done");
        summary();
    end

    initial begin
        wait_cyc(3);
        check("R1 pad_oe at reset", pad_oe, 8'h00);
        check("R1 rvalid at reset", {7'd0, bus_rvalid}, 8'h00);
        rst_n = 1'b1;
        wait_cyc(1);
        bus_read(2'd0, 8'hFF, "R1 direction reset");
        bus_read(2'd2, 8'h00, "R1 latch reset");
        wait_cyc(1);
        check("R5 rvalid drops", {7'd0, bus_rvalid}, 8'h00);

        // Pins 4..7 outputs, 0..3 inputs.
        bus_write(2'd0, 8'h0F);
        check("R6 pad_oe", pad_oe, 8'hF0);
        bus_write(2'd1, 8'hA5);
        check("R6 pad_out from port write", pad_out, 8'hA0);
        bus_read(2'd2, 8'hA5, "R2 port write into latch");
        ext = 8'h3C;
        wait_cyc(3);
        bus_read(2'd1, 8'hAC, "R4 port read pads");
        bus_read(2'd2, 8'hA5, "R3 latch read ignores pins");
        bus_write(2'd2, 8'h5A);
        bus_read(2'd2, 8'h5A, "R2 latch write");
        bus_read(2'd0, 8'h0F, "R2 direction unchanged");
        check("R6 pad_out", pad_out, 8'h50);
        wait_cyc(3);

        // Synchroniser latency boundary.
        ext = 8'h03;
        wait_cyc(1);
        bus_read(2'd1, 8'h5C, "R4 one cycle old level");
        bus_read(2'd1, 8'h53, "R4 two cycles new level");

        // Unused address.
        bus_write(2'd3, 8'hFF);
        bus_read(2'd3, 8'h00, "R5 address 3 reads zero");
        bus_read(2'd2, 8'h5A, "R5 address 3 write ignored latch");
        bus_read(2'd0, 8'h0F, "R5 address 3 write ignored dir");

        // Bit commands on latch address.
        bitcmd(2'd2, 2'b01, 3'd0);
        bus_read(2'd2, 8'h5B, "R7 set bit0");
        bitcmd(2'd2, 2'b11, 3'd7);
        bus_read(2'd2, 8'hDB, "R7 toggle bit7");
        bitcmd(2'd2, 2'b10, 3'd3);
        bus_read(2'd2, 8'hD3, "R8 clear bit3 keeps others");
        bitcmd(2'd2, 2'b00, 3'd5);
        bus_read(2'd2, 8'hD3, "R7 none op");

        // Write wins over bit command.
        bus_addr = 2'd2; bus_wdata = 8'h11; bus_wr = 1'b1; bit_op = 2'b01; bit_idx = 3'd7;
        @(negedge clk);
        bus_wr = 1'b0; bit_op = 2'b00;
        bus_read(2'd2, 8'h11, "R7 bit command ignored during write");

        // Port-address bit command copies pad levels.
        wait_cyc(4);
        bitcmd(2'd1, 2'b01, 3'd6);
        bus_read(2'd2, 8'h53, "R9 port bit command overwrites inputs");
        bus_write(2'd2, 8'h11);
        bitcmd(2'd2, 2'b01, 3'd6);
        bus_read(2'd2, 8'h51, "R8 latch bit command preserves inputs");
        wait_cyc(4);
        bitcmd(2'd1, 2'b10, 3'd4);
        bus_read(2'd2, 8'h43, "R9 port clear bit4");

        // Turn every pin into an output.
        bus_write(2'd0, 8'h00);
        check("R11 pad_oe all driven", pad_oe, 8'hFF);
        check("R11 drives corrupted latch", pad_out, 8'h43);

        // Direction bit commands.
        bitcmd(2'd0, 2'b11, 3'd0);
        bus_read(2'd0, 8'h01, "R10 toggle direction bit0");
        check("R10 pad_oe after toggle", pad_oe, 8'hFE);
        bitcmd(2'd0, 2'b01, 3'd5);
        bus_read(2'd0, 8'h21, "R10 set direction bit5");

        wait_cyc(3);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL R5 missing responses actual=%0d expected=0", exp_q.size());
        end
        summary();
    end
endmodule